// File: doc/BRIEF.md
# Indirect 64-bit Register Bridge

This block lets a narrow 32-bit host register interface reach a wide 64-bit register space that sits behind a request/acknowledge port. The host sees a small window: two 32-bit data words that together form one 64-bit value, a command word, a reset word and a status word. Writing the command word launches exactly one 64-bit access on the downstream port. The top bit of the command picks the direction and the remaining 31 bits give the downstream register address.

For a downstream write, the host first loads the upper data word, then the lower one, then issues the command with the direction bit set. The staged 64-bit value is held on the downstream port until the far side acknowledges. For a downstream read, the host issues the command with the direction bit clear, waits for busy to drop, then reads the two data words. Any fault (an error response, a request that is never answered, or a command issued while a previous one is still open) latches a sticky error flag. Only a write to the reset word clears that flag.

Top module: `rwb_bridge`

## Requirements
- R1: After reset, the downstream request is low, STATUS reads 0, and both data words read 0.
- R2: Window byte offsets are: 0x00 upper data word (bits 63:32), 0x04 lower data word (bits 31:0), 0x08 command, 0x18 reset, 0x1C status. STATUS bit 31 is the error flag and bit 0 is busy; its other bits read 0. The command word reads back as the last accepted command. Any other offset reads 0.
- R3: A write to the command word with bit 31 = 1 while idle raises `dn_req` with `dn_we` = 1 from the next cycle. `dn_addr` equals command bits 30:0 and `dn_wdata` equals {upper word, lower word}. All of these are held stable until `dn_ack`.
- R4: A write to the command word with bit 31 = 0 while idle raises `dn_req` with `dn_we` = 0. On the edge where `dn_ack` is high and `dn_err` is low, `dn_rdata[63:32]` is captured into the upper word and `dn_rdata[31:0]` into the lower word.
- R5: Busy (STATUS bit 0) and `dn_req` are high from the cycle after an accepted command up to and including the cycle in which `dn_ack` arrives, and both are low afterwards.
- R6: A write to the command word while busy (including the cycle in which `dn_ack` arrives) is ignored: address and direction do not change, and the error flag is set.
- R7: Writes to either data word while busy are ignored.
- R8: `dn_ack` together with `dn_err` ends the access, sets the error flag, and leaves both data words unchanged.
- R9: A request that has seen no acknowledge for 256 cycles ends on the 256th edge after the command write. It sets the error flag and returns the bridge to idle.
- R10: The error flag stays set until any value is written to the reset word. That write clears error, busy and both data words, and drops `dn_req`.
- R11: A reset-word write in the same cycle as `dn_ack` takes priority: the returned data is not captured and the error flag is left clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host write strobe for one cycle |
| hst_addr | input | 5 | Host window byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` (combinational) |
| dn_req | output | 1 | Downstream request, held until acknowledge |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 31 | Downstream register address |
| dn_wdata | output | 64 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge, one cycle |
| dn_err | input | 1 | Downstream error, valid with `dn_ack` |
| dn_rdata | input | 64 | Downstream read data, valid with `dn_ack` |

## Verification
Two events can land on the same edge: the downstream acknowledge, and a host write to the reset word or to the command word. The bench provokes each collision by raising `dn_ack` in the same cycle as the host strobe.

For a reset collision, it expects both data words to read zero, the error flag to stay clear and the request to be gone. For a command collision, it expects the acknowledged access to finish normally, the new command to be dropped, and the error flag to be set. Expected values come from a scoreboard queue that is filled by the driver and drained by a monitor on the falling clock edge.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
    // Window byte offsets (host decode depends on these values)
    localparam logic [7:0] OFS_HI  = 8'h00;
    localparam logic [7:0] OFS_LO  = 8'h04;
    localparam logic [7:0] OFS_CMD = 8'h08;
    localparam logic [7:0] OFS_RST = 8'h18;
    localparam logic [7:0] OFS_STS = 8'h1C;
endpackage

// File: rtl/rwb_tmo.sv
module rwb_tmo #(
    parameter int TMO_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic expired
);
    localparam int CNT_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
    localparam logic [CNT_W-1:0] LIM = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || ack) begin
            cnt_d = '0;
        end else if (cnt_q != LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && !ack && (cnt_q == LIM);
endmodule

// File: rtl/rwb_core.sv
module rwb_core
    import rwb_pkg::*;
#(
    parameter int HW   = 32,
    parameter int HA_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [HA_W-1:0] wr_ofs,
    input  logic [HW-1:0]   wr_data,
    input  logic            dn_ack,
    input  logic            dn_err,
    input  logic [2*HW-1:0] dn_rdata,
    input  logic            tmo,
    output logic [HW-1:0]   hi,
    output logic [HW-1:0]   lo,
    output logic            cmd_we,
    output logic [HW-2:0]   cmd_addr,
    output logic            busy,
    output logic            err
);
    typedef struct packed {
        logic [HW-1:0] hi;
        logic [HW-1:0] lo;
        logic          we;
        logic [HW-2:0] addr;
        logic          busy;
        logic          err;
    } st_t;

    st_t st_d, st_q;

    logic w_hi, w_lo, w_cmd, w_rst;

    always_comb begin
        w_hi  = wr_en && (wr_ofs == OFS_HI[HA_W-1:0]);
        w_lo  = wr_en && (wr_ofs == OFS_LO[HA_W-1:0]);
        w_cmd = wr_en && (wr_ofs == OFS_CMD[HA_W-1:0]);
        w_rst = wr_en && (wr_ofs == OFS_RST[HA_W-1:0]);
    end

    always_comb begin
        st_d = st_q;
        if (w_rst) begin
            st_d = '0;
        end else begin
            // completion of an open access
            if (st_q.busy) begin
                if (dn_ack) begin
                    st_d.busy = 1'b0;
                    if (dn_err) begin
                        st_d.err = 1'b1;
                    end else if (!st_q.we) begin
                        st_d.hi = dn_rdata[2*HW-1:HW];
                        st_d.lo = dn_rdata[HW-1:0];
                    end
                end else if (tmo) begin
                    st_d.busy = 1'b0;
                    st_d.err  = 1'b1;
                end
            end
            // host writes
            if (w_hi && !st_q.busy) st_d.hi = wr_data;
            if (w_lo && !st_q.busy) st_d.lo = wr_data;
            if (w_cmd) begin
                if (st_q.busy) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.we   = wr_data[HW-1];
                    st_d.addr = wr_data[HW-2:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi       = st_q.hi;
    assign lo       = st_q.lo;
    assign cmd_we   = st_q.we;
    assign cmd_addr = st_q.addr;
    assign busy     = st_q.busy;
    assign err      = st_q.err;
endmodule

// File: rtl/rwb_rdmux.sv
module rwb_rdmux
    import rwb_pkg::*;
#(
    parameter int HW   = 32,
    parameter int HA_W = 5
) (
    input  logic [HA_W-1:0] rd_ofs,
    input  logic [HW-1:0]   hi,
    input  logic [HW-1:0]   lo,
    input  logic            cmd_we,
    input  logic [HW-2:0]   cmd_addr,
    input  logic            busy,
    input  logic            err,
    output logic [HW-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        if (rd_ofs == OFS_HI[HA_W-1:0])       rdata = hi;
        else if (rd_ofs == OFS_LO[HA_W-1:0])  rdata = lo;
        else if (rd_ofs == OFS_CMD[HA_W-1:0]) rdata = {cmd_we, cmd_addr};
        else if (rd_ofs == OFS_STS[HA_W-1:0]) rdata = {err, {(HW-2){1'b0}}, busy};
    end
endmodule

// File: rtl/rwb_bridge.sv
module rwb_bridge #(
    parameter int HW      = 32,
    parameter int HA_W    = 5,
    parameter int TMO_CYC = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hst_we,
    input  logic [HA_W-1:0] hst_addr,
    input  logic [HW-1:0]   hst_wdata,
    output logic [HW-1:0]   hst_rdata,
    output logic            dn_req,
    output logic            dn_we,
    output logic [HW-2:0]   dn_addr,
    output logic [2*HW-1:0] dn_wdata,
    input  logic            dn_ack,
    input  logic            dn_err,
    input  logic [2*HW-1:0] dn_rdata
);
    logic [HW-1:0] hi_w, lo_w;
    logic          we_w, busy_w, err_w, tmo_w;
    logic [HW-2:0] addr_w;

    rwb_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy_w),
        .ack     (dn_ack),
        .expired (tmo_w)
    );

    rwb_core #(.HW(HW), .HA_W(HA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hst_we),
        .wr_ofs   (hst_addr),
        .wr_data  (hst_wdata),
        .dn_ack   (dn_ack),
        .dn_err   (dn_err),
        .dn_rdata (dn_rdata),
        .tmo      (tmo_w),
        .hi       (hi_w),
        .lo       (lo_w),
        .cmd_we   (we_w),
        .cmd_addr (addr_w),
        .busy     (busy_w),
        .err      (err_w)
    );

    rwb_rdmux #(.HW(HW), .HA_W(HA_W)) u_rdmux (
        .rd_ofs   (hst_addr),
        .hi       (hi_w),
        .lo       (lo_w),
        .cmd_we   (we_w),
        .cmd_addr (addr_w),
        .busy     (busy_w),
        .err      (err_w),
        .rdata    (hst_rdata)
    );

    assign dn_req   = busy_w;
    assign dn_we    = we_w;
    assign dn_addr  = addr_w;
    assign dn_wdata = {hi_w, lo_w};
endmodule

// File: rtl/rwb_chk.sv
module rwb_chk
    import rwb_pkg::*;
#(
    parameter int HW   = 32,
    parameter int HA_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hst_we,
    input logic [HA_W-1:0] hst_addr,
    input logic            dn_req,
    input logic            dn_we,
    input logic [HW-2:0]   dn_addr,
    input logic [2*HW-1:0] dn_wdata,
    input logic            dn_ack,
    input logic            dn_err,
    input logic            err,
    input logic            tmo
);
    logic rst_wr, cmd_wr;
    assign rst_wr = hst_we && (hst_addr == OFS_RST[HA_W-1:0]);
    assign cmd_wr = hst_we && (hst_addr == OFS_CMD[HA_W-1:0]);

    p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack && !tmo && !rst_wr) |=> (dn_req && $stable(dn_wdata) && $stable(dn_addr) && $stable(dn_we)));

    p_ack_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ack) |=> !dn_req);

    p_busy_cmd_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && cmd_wr) |=> (err && $stable(dn_addr) && $stable(dn_we)));

    p_dn_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ack && dn_err && !rst_wr) |=> err);

    p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !rst_wr) |=> (err && !dn_req));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !rst_wr) |=> err);

    p_reset_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> (!err && !dn_req && (dn_wdata == '0)));
endmodule

bind rwb_bridge rwb_chk #(.HW(HW), .HA_W(HA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hst_we   (hst_we),
    .hst_addr (hst_addr),
    .dn_req   (dn_req),
    .dn_we    (dn_we),
    .dn_addr  (dn_addr),
    .dn_wdata (dn_wdata),
    .dn_ack   (dn_ack),
    .dn_err   (dn_err),
    .err      (err_w),
    .tmo      (tmo_w)
);

// File: tb/sim_rwb_bridge.sv
`timescale 1ns/1ps
module sim_rwb_bridge;
    localparam logic [4:0] A_HI = 5'h00, A_LO = 5'h04, A_CMD = 5'h08,
                           A_RST = 5'h18, A_STS = 5'h1C;
    localparam int S_RD = 0, S_REQ = 1, S_WE = 2, S_ADDR = 3, S_WD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_we = 1'b0;
    logic [4:0]  hst_addr = 5'h00;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        dn_req, dn_we;
    logic [30:0] dn_addr;
    logic [63:0] dn_wdata;
    logic        dn_ack = 1'b0;
    logic        dn_err = 1'b0;
    logic [63:0] dn_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] exp;
        int          sel;
        string       tag;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    rwb_bridge u0 (
        .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .dn_req(dn_req),
        .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata)
    );

    // monitor: pops expected items and compares on the falling edge
    always @(negedge clk) begin
        item_t it;
        logic [63:0] act;
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.sel)
                S_RD:    act = {32'h0, hst_rdata};
                S_REQ:   act = {63'h0, dn_req};
                S_WE:    act = {63'h0, dn_we};
                S_ADDR:  act = {33'h0, dn_addr};
                default: act = dn_wdata;
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int sel, input logic [63:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.sel = sel; it.tag = tag;
        q.push_back(it);
    endtask

    // port expectation, compared at the coming falling edge
    task automatic exp_port(input int sel, input logic [63:0] exp, input string tag);
        push(sel, exp, tag);
    endtask

    // register read expectation; waits for the compare
    task automatic exp_reg(input logic [4:0] ofs, input logic [31:0] exp, input string tag);
        hst_addr = ofs;
        push(S_RD, {32'h0, exp}, tag);
        @(negedge clk);
        #1;
    endtask

    task automatic hwr(input logic [4:0] ofs, input logic [31:0] d);
        @(posedge clk); #1;
        hst_we = 1'b1; hst_addr = ofs; hst_wdata = d;
        @(posedge clk); #1;
        hst_we = 1'b0;
    endtask

    task automatic dack(input logic e, input logic [63:0] rd);
        @(posedge clk); #1;
        dn_ack = 1'b1; dn_err = e; dn_rdata = rd;
        @(posedge clk); #1;
        dn_ack = 1'b0; dn_err = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        exp_port(S_REQ, 0, "R1 req");
        exp_reg(A_STS, 32'h0, "R1 status");
        exp_reg(A_HI, 32'h0, "R1 data0");
        exp_reg(A_LO, 32'h0, "R1 data1");

        // R3 / R5 / R7 downstream write
        hwr(A_HI, 32'hA1A2_A3A4);
        hwr(A_LO, 32'hB1B2_B3B4);
        hwr(A_CMD, 32'h8000_0123);
        exp_port(S_REQ, 1, "R3 req");
        exp_port(S_WE, 1, "R3 we");
        exp_port(S_ADDR, 64'h123, "R3 addr");
        exp_port(S_WD, 64'hA1A2_A3A4_B1B2_B3B4, "R3 wdata");
        exp_reg(A_STS, 32'h0000_0001, "R5 busy");
        repeat (10) @(posedge clk);
        hwr(A_HI, 32'hDEAD_0000);
        hwr(A_LO, 32'h0000_BEEF);
        exp_port(S_WD, 64'hA1A2_A3A4_B1B2_B3B4, "R7 wdata held");
        exp_reg(A_HI, 32'hA1A2_A3A4, "R7 data0 unchanged");
        dack(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        exp_port(S_REQ, 0, "R5 req dropped");
        exp_reg(A_STS, 32'h0, "R5 idle no err");
        exp_reg(A_LO, 32'hB1B2_B3B4, "R3 write data not overwritten");

        // R4 downstream read, R2 command readback
        hwr(A_CMD, 32'h0000_0456);
        exp_port(S_WE, 0, "R4 we");
        exp_port(S_ADDR, 64'h456, "R4 addr");
        exp_reg(A_CMD, 32'h0000_0456, "R2 cmd readback");
        dack(1'b0, 64'h1122_3344_5566_7788);
        exp_reg(A_HI, 32'h1122_3344, "R4 data0 upper");
        exp_reg(A_LO, 32'h5566_7788, "R4 data1 lower");
        exp_reg(A_STS, 32'h0, "R4 status");
        exp_reg(5'h10, 32'h0, "R2 unmapped");

        // R6 command while busy, R10 sticky + reset
        hwr(A_CMD, 32'h0000_00AA);
        hwr(A_CMD, 32'h8000_0777);
        exp_port(S_ADDR, 64'h0AA, "R6 addr kept");
        exp_port(S_WE, 0, "R6 we kept");
        exp_reg(A_STS, 32'h8000_0001, "R6 err while busy");
        dack(1'b0, 64'h0102_0304_0506_0708);
        exp_reg(A_STS, 32'h8000_0000, "R10 err sticky");
        hwr(A_HI, 32'h5555_5555);
        exp_reg(A_STS, 32'h8000_0000, "R10 err still set");
        hwr(A_RST, 32'h1234_5678);
        exp_reg(A_STS, 32'h0, "R10 cleared");
        exp_reg(A_HI, 32'h0, "R10 data0 cleared");
        exp_reg(A_LO, 32'h0, "R10 data1 cleared");

        // R8 error response
        hwr(A_CMD, 32'h0000_0321);
        dack(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        exp_reg(A_STS, 32'h8000_0000, "R8 err set");
        exp_reg(A_HI, 32'h0, "R8 no capture");
        hwr(A_RST, 32'h0);

        // R9 timeout
        hwr(A_CMD, 32'h0000_0099);
        repeat (255) @(posedge clk);
        #1;
        exp_reg(A_STS, 32'h0000_0001, "R9 busy at 255");
        @(posedge clk); #1;
        exp_reg(A_STS, 32'h8000_0000, "R9 timeout err");
        exp_port(S_REQ, 0, "R9 idle");
        hwr(A_RST, 32'h0);

        // R11 reset collides with ack
        hwr(A_CMD, 32'h0000_0042);
        @(posedge clk); #1;
        hst_we = 1'b1; hst_addr = A_RST; hst_wdata = '0;
        dn_ack = 1'b1; dn_err = 1'b1; dn_rdata = 64'hDEAD_BEEF_CAFE_F00D;
        @(posedge clk); #1;
        hst_we = 1'b0; dn_ack = 1'b0; dn_err = 1'b0;
        exp_port(S_REQ, 0, "R11 req");
        exp_reg(A_HI, 32'h0, "R11 data0");
        exp_reg(A_STS, 32'h0, "R11 status");

        // R6 command collides with ack
        hwr(A_CMD, 32'h0000_0050);
        @(posedge clk); #1;
        hst_we = 1'b1; hst_addr = A_CMD; hst_wdata = 32'h8000_0060;
        dn_ack = 1'b1; dn_rdata = 64'h0000_0001_0000_0002;
        @(posedge clk); #1;
        hst_we = 1'b0; dn_ack = 1'b0;
        exp_port(S_REQ, 0, "R6 cmd on ack dropped");
        exp_reg(A_STS, 32'h8000_0000, "R6 cmd on ack err");
        exp_reg(A_LO, 32'h0000_0002, "R6 ack data captured");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule